// File: doc/BRIEF.md
# Dual-Clock FIFO with Mark and Retransmit

This block buffers words between a write clock domain and a read clock domain. Word width and depth are parameters. Write and read pointers travel between the domains as Gray code through two-flop synchronizers. Each flag is active low and is updated only by the clock of its own side. Full, half-full and almost-full belong to the write side. Empty and almost-empty belong to the read side. A fixed number of locations, between four and eight, is held back from writing. This leaves margin for the synchronizer lag.

The write side can advance its pointer without storing anything, which masks a write. The read side can likewise advance its pointer without presenting a word, which skips a read. A read issued with the mark input high records its own location. A later rising edge on the retransmit input walks the read pointer back to that location, and reads then replay the stored words from there. The almost-flag thresholds come in as ports from a separate configuration block.

There are two resets. A master reset clears both pointers and the output register, and also raises a request for the configuration block to restore its defaults. A partial reset clears the pointers and the output register only.

Top module: `fifo_rt_top`

## Requirements
- R1: Words leave the read port in the order in which they were accepted on the write port.
- R2: A write cycle with `wen_i`=1 and `ie_i`=0 advances the write pointer but leaves the addressed location holding its previous contents.
- R3: A read cycle with `ren_i`=1 and `oe_i`=0 advances the read pointer but presents no word: `dval_n_o` stays 1 and `rdata_o` is not updated.
- R4: `dval_n_o` is 0 in exactly the read-clock cycle that follows an accepted read with `oe_i`=1, and `rdata_o` carries that word in the same cycle.
- R5: While `empty_n_o` is 0, `ren_i` has no effect and `dval_n_o` stays 1.
- R6: `full_n_o` goes to 0 when the stored count reaches DEPTH-RSV (12 by default). While it is 0, `wen_i` is ignored, so no more than DEPTH-RSV words can ever be read back.
- R7: `hfull_n_o` is 0 whenever the stored count, as seen by the write side, is DEPTH/2 or more. It is updated only on the write clock.
- R8: `afull_n_o` is 0 whenever the free space (DEPTH-RSV minus the stored count) is at or below `af_off_i`.
- R9: `aempty_n_o` is 0 whenever the stored count, as seen by the read side, is at or below `ae_off_i`.
- R10: A rising edge on `rt_i` moves the read pointer back to the marked location. Reads then return the words from that location up to the write pointer, and the flags follow the restored pointer.
- R11: A retransmit edge is ignored when no read has been accepted since reset, or when more than DEPTH words have been written since the mark.
- R12: Either reset leaves `empty_n_o`=0, `aempty_n_o`=0, `full_n_o`=1, `hfull_n_o`=1, `dval_n_o`=1 and `rdata_o`=0. `cfg_dflt_o` is 1 only during a master reset and stays 0 during a partial reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| mrst_n_i | input | 1 | Master reset, active low, asynchronous |
| prst_n_i | input | 1 | Partial reset, active low, asynchronous |
| wen_i | input | 1 | Write request |
| ie_i | input | 1 | Store enable; 0 masks the write |
| wdata_i | input | DATA_W | Write word |
| ren_i | input | 1 | Read request |
| oe_i | input | 1 | Present enable; 0 skips the read |
| mark_i | input | 1 | Record the location of this read |
| rt_i | input | 1 | Retransmit request, acted on at its rising edge |
| ae_off_i | input | ADDR_W+1 | Almost-empty threshold |
| af_off_i | input | ADDR_W+1 | Almost-full threshold |
| rdata_o | output | DATA_W | Read word register |
| dval_n_o | output | 1 | Read word valid, active low |
| empty_n_o | output | 1 | Empty, active low |
| aempty_n_o | output | 1 | Almost empty, active low |
| full_n_o | output | 1 | Full, active low |
| hfull_n_o | output | 1 | Half full, active low |
| afull_n_o | output | 1 | Almost full, active low |
| cfg_dflt_o | output | 1 | Request to the configuration block to restore defaults |

## Verification
Plain bursts check ordering and data-valid timing. A burst with one masked write lands on a location that a partial reset left holding old data, so the replayed word shows that the location was not overwritten. A read burst with one skipped beat separates pointer advance from word presentation. A fill well past capacity shows that full blocks writes and shows where the half-full and almost flags switch. Two retransmit sequences close the set: one with a fresh mark that must replay, and one whose mark was overrun by more than a depth of writes that must be ignored.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

    // Gray to binary conversion over a 32-bit carrier; callers cast to width.
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/fifo_rt_gsync.sv
module fifo_rt_gsync #(
    parameter int W = 5
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/fifo_rt_wctl.sv
module fifo_rt_wctl
    import fifo_rt_pkg::*;
#(
    parameter int AW  = 4,
    parameter int RSV = 4
) (
    input  logic          wclk_i,
    input  logic          rst_n_i,
    input  logic          wen_i,
    input  logic          ie_i,
    input  logic [AW:0]   af_off_i,
    input  logic [AW:0]   rgray_ws_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [AW:0]   wgray_o,
    output logic          full_n_o,
    output logic          hfull_n_o,
    output logic          afull_n_o
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] CAP  = PW'(DEPTH - RSV);
    localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] wgray;
        logic          full_n;
        logic          hfull_n;
        logic          afull_n;
    } wst_t;

    wst_t st_d, st_q;
    logic          push;
    logic [PW-1:0] rbin, cnt, room;

    always_comb begin
        st_d = st_q;
        rbin = PW'(gray_to_bin(32'(rgray_ws_i)));
        push = wen_i && st_q.full_n;
        if (push) begin
            st_d.wptr = st_q.wptr + PW'(1);
        end
        st_d.wgray = PW'(bin_to_gray(32'(st_d.wptr)));
        cnt  = st_d.wptr - rbin;
        room = (cnt >= CAP) ? '0 : (CAP - cnt);
        st_d.full_n  = !(cnt >= CAP);
        st_d.hfull_n = !(cnt >= HALF);
        st_d.afull_n = !(room <= af_off_i);
    end

    always_ff @(posedge wclk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q         <= '0;
            st_q.full_n  <= 1'b1;
            st_q.hfull_n <= 1'b1;
            st_q.afull_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign we_o      = push && ie_i;
    assign waddr_o   = st_q.wptr[AW-1:0];
    assign wgray_o   = st_q.wgray;
    assign full_n_o  = st_q.full_n;
    assign hfull_n_o = st_q.hfull_n;
    assign afull_n_o = st_q.afull_n;
endmodule

// File: rtl/fifo_rt_rctl.sv
module fifo_rt_rctl
    import fifo_rt_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          rclk_i,
    input  logic          rst_n_i,
    input  logic          ren_i,
    input  logic          oe_i,
    input  logic          mark_i,
    input  logic          rt_i,
    input  logic [AW:0]   ae_off_i,
    input  logic [AW:0]   wgray_rs_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [AW-1:0] raddr_o,
    output logic [AW:0]   rgray_o,
    output logic [DW-1:0] rdata_o,
    output logic          dval_n_o,
    output logic          empty_n_o,
    output logic          aempty_n_o
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [PW-1:0] rptr;
        logic [PW-1:0] rgray;
        logic [PW-1:0] mark;
        logic          mark_vld;
        logic          rd_seen;
        logic          rewind;
        logic          rt_prev;
        logic [DW-1:0] dout;
        logic          dval_n;
        logic          empty_n;
        logic          aempty_n;
    } rst_t;

    rst_t st_d, st_q;
    logic          pop, rt_rise;
    logic [PW-1:0] wbin, rcnt, mark_dist;

    always_comb begin
        st_d        = st_q;
        st_d.dval_n = 1'b1;
        wbin        = PW'(gray_to_bin(32'(wgray_rs_i)));
        pop         = ren_i && st_q.empty_n && !st_q.rewind;
        rt_rise     = rt_i && !st_q.rt_prev;
        st_d.rt_prev = rt_i;

        // a mark that the writer has lapped by more than one depth is stale
        mark_dist = wbin - st_q.mark;
        if (mark_dist > PW'(DEPTH)) begin
            st_d.mark_vld = 1'b0;
        end

        if (pop) begin
            st_d.rptr    = st_q.rptr + PW'(1);
            st_d.rd_seen = 1'b1;
            if (mark_i) begin
                st_d.mark     = st_q.rptr;
                st_d.mark_vld = 1'b1;
            end
            if (oe_i) begin
                st_d.dout   = mem_rdata_i;
                st_d.dval_n = 1'b0;
            end
        end

        // rewind one location per cycle so the pointer stays Gray-safe
        if (st_q.rewind) begin
            if (st_q.rptr == st_q.mark) begin
                st_d.rewind = 1'b0;
            end else begin
                st_d.rptr = st_q.rptr - PW'(1);
            end
        end else if (rt_rise && st_q.rd_seen && st_q.mark_vld) begin
            st_d.rewind = 1'b1;
        end

        st_d.rgray    = PW'(bin_to_gray(32'(st_d.rptr)));
        rcnt          = wbin - st_d.rptr;
        st_d.empty_n  = (rcnt != '0);
        st_d.aempty_n = !(rcnt <= ae_off_i);
    end

    always_ff @(posedge rclk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q          <= '0;
            st_q.mark_vld <= 1'b1;
            st_q.dval_n   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr_o    = st_q.rptr[AW-1:0];
    assign rgray_o    = st_q.rgray;
    assign rdata_o    = st_q.dout;
    assign dval_n_o   = st_q.dval_n;
    assign empty_n_o  = st_q.empty_n;
    assign aempty_n_o = st_q.aempty_n;
endmodule

// File: rtl/fifo_rt_top.sv
module fifo_rt_top #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int RSV    = 4
) (
    input  logic              wclk_i,
    input  logic              rclk_i,
    input  logic              mrst_n_i,
    input  logic              prst_n_i,
    input  logic              wen_i,
    input  logic              ie_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ren_i,
    input  logic              oe_i,
    input  logic              mark_i,
    input  logic              rt_i,
    input  logic [ADDR_W:0]   ae_off_i,
    input  logic [ADDR_W:0]   af_off_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              dval_n_o,
    output logic              empty_n_o,
    output logic              aempty_n_o,
    output logic              full_n_o,
    output logic              hfull_n_o,
    output logic              afull_n_o,
    output logic              cfg_dflt_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    logic              rst_n;
    logic              we;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_rdata;
    logic              cfg_dflt_q;

    assign rst_n = mrst_n_i & prst_n_i;

    always_ff @(posedge wclk_i or negedge mrst_n_i) begin
        if (!mrst_n_i) cfg_dflt_q <= 1'b1;
        else           cfg_dflt_q <= 1'b0;
    end
    assign cfg_dflt_o = cfg_dflt_q;

    always_ff @(posedge wclk_i) begin
        if (we) mem_q[waddr] <= wdata_i;
    end
    assign mem_rdata = mem_q[raddr];

    fifo_rt_gsync #(.W(PW)) u_w2r (
        .clk_i(rclk_i), .rst_n_i(rst_n), .d_i(wgray), .q_o(wgray_rs)
    );
    fifo_rt_gsync #(.W(PW)) u_r2w (
        .clk_i(wclk_i), .rst_n_i(rst_n), .d_i(rgray), .q_o(rgray_ws)
    );

    fifo_rt_wctl #(.AW(ADDR_W), .RSV(RSV)) u_wctl (
        .wclk_i(wclk_i), .rst_n_i(rst_n), .wen_i(wen_i), .ie_i(ie_i),
        .af_off_i(af_off_i), .rgray_ws_i(rgray_ws), .we_o(we),
        .waddr_o(waddr), .wgray_o(wgray), .full_n_o(full_n_o),
        .hfull_n_o(hfull_n_o), .afull_n_o(afull_n_o)
    );

    fifo_rt_rctl #(.AW(ADDR_W), .DW(DATA_W)) u_rctl (
        .rclk_i(rclk_i), .rst_n_i(rst_n), .ren_i(ren_i), .oe_i(oe_i),
        .mark_i(mark_i), .rt_i(rt_i), .ae_off_i(ae_off_i),
        .wgray_rs_i(wgray_rs), .mem_rdata_i(mem_rdata), .raddr_o(raddr),
        .rgray_o(rgray), .rdata_o(rdata_o), .dval_n_o(dval_n_o),
        .empty_n_o(empty_n_o), .aempty_n_o(aempty_n_o)
    );
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk
    import fifo_rt_pkg::*;
#(
    parameter int AW = 4
) (
    input logic        wclk,
    input logic        rclk,
    input logic        rst_n,
    input logic        ren,
    input logic        oe,
    input logic        dval_n,
    input logic        empty_n,
    input logic        full_n,
    input logic        hfull_n,
    input logic        afull_n,
    input logic [AW:0] wgray,
    input logic [AW:0] rgray_ws
);
    localparam int PW = AW + 1;
    logic [PW-1:0] wbin, rbin, span;

    assign wbin = PW'(gray_to_bin(32'(wgray)));
    assign rbin = PW'(gray_to_bin(32'(rgray_ws)));
    assign span = wbin - rbin;

    // R4
    dval_after_read_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !dval_n |-> $past(ren && oe && empty_n));

    // R5
    empty_no_read_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |=> dval_n);

    // R6
    full_holds_ptr_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |=> $stable(wgray));

    // R6
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        span <= PW'(1 << AW));

    // R7
    full_implies_half_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> (!hfull_n && !afull_n));
endmodule

bind fifo_rt_top fifo_rt_chk #(.AW(ADDR_W)) u_chk (
    .wclk(wclk_i), .rclk(rclk_i), .rst_n(rst_n), .ren(ren_i), .oe(oe_i),
    .dval_n(dval_n_o), .empty_n(empty_n_o), .full_n(full_n_o),
    .hfull_n(hfull_n_o), .afull_n(afull_n_o), .wgray(wgray),
    .rgray_ws(rgray_ws)
);

// File: tb/fifo_rt_top_tb_top.sv
module fifo_rt_top_tb_top;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int CAP = 12;

    logic wclk = 0, rclk = 0;
    logic mrst_n = 0, prst_n = 1;
    logic wen = 0, ie = 1, ren = 0, oe = 1, mark = 0, rt = 0;
    logic [DW-1:0] wdata = '0;
    logic [AW:0] ae_off = 5'd4, af_off = 5'd3;
    logic [DW-1:0] rdata;
    logic dval_n, empty_n, aempty_n, full_n, hfull_n, afull_n, cfg_dflt;
    int nchk = 0, nerr = 0;
    bit done = 0;

    always #2 wclk = ~wclk;
    initial begin #1; forever #2 rclk = ~rclk; end

    fifo_rt_top #(.DATA_W(DW), .ADDR_W(AW), .RSV(4)) dut_i (
        .wclk_i(wclk), .rclk_i(rclk), .mrst_n_i(mrst_n), .prst_n_i(prst_n),
        .wen_i(wen), .ie_i(ie), .wdata_i(wdata), .ren_i(ren), .oe_i(oe),
        .mark_i(mark), .rt_i(rt), .ae_off_i(ae_off), .af_off_i(af_off),
        .rdata_o(rdata), .dval_n_o(dval_n), .empty_n_o(empty_n),
        .aempty_n_o(aempty_n), .full_n_o(full_n), .hfull_n_o(hfull_n),
        .afull_n_o(afull_n), .cfg_dflt_o(cfg_dflt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [DW-1:0] d, input logic en);
        @(negedge wclk); wen = 1; ie = en; wdata = d;
        @(posedge wclk); #1;
    endtask
    task automatic wr_stop();
        @(negedge wclk); wen = 0; ie = 1;
        repeat (10) @(posedge wclk);
    endtask
    task automatic rd(input logic o, input logic m);
        @(negedge rclk); ren = 1; oe = o; mark = m;
        @(posedge rclk); #1;
    endtask
    task automatic rd_stop();
        @(negedge rclk); ren = 0; oe = 1; mark = 0;
    endtask
    task automatic part_reset();
        @(negedge wclk); prst_n = 0; #1;
        chk("R12 cfg_dflt in partial reset", cfg_dflt, 0);
        repeat (2) @(negedge wclk); prst_n = 1;
        repeat (4) @(posedge wclk);
    endtask
    task automatic pulse_rt();
        @(negedge rclk); rt = 1; @(negedge rclk); rt = 0;
        repeat (40) @(posedge rclk);
    endtask

    task automatic t_reset();
        #7;
        chk("R12 empty_n", empty_n, 0); chk("R12 aempty_n", aempty_n, 0);
        chk("R12 full_n", full_n, 1);   chk("R12 hfull_n", hfull_n, 1);
        chk("R12 dval_n", dval_n, 1);   chk("R12 rdata", rdata, 0);
        chk("R12 cfg_dflt in master reset", cfg_dflt, 1);
        mrst_n = 1;
        repeat (4) @(posedge wclk); #1;
        chk("R12 cfg_dflt released", cfg_dflt, 0);
    endtask

    task automatic t_order();
        for (int i = 0; i < 10; i++) wr(16'h100 + 16'(i), 1);
        wr_stop();
        chk("R9 ten words not almost empty", aempty_n, 1);
        for (int i = 0; i < 10; i++) begin
            rd(1, 0);
            chk("R4 dval low with word", dval_n, 0);
            chk("R1 order", rdata, 16'h100 + 16'(i));
            if (i == 4) chk("R9 five left", aempty_n, 1);
            if (i == 5) chk("R9 four left", aempty_n, 0);
        end
        chk("R5 empty after drain", empty_n, 0);
        for (int i = 0; i < 3; i++) begin
            rd(1, 0);
            chk("R5 read while empty ignored", dval_n, 1);
        end
        rd_stop();
    endtask

    task automatic t_mask();
        part_reset();
        chk("R12 rdata cleared by partial reset", rdata, 0);
        chk("R12 empty after partial reset", empty_n, 0);
        wr(16'h0A0, 1); wr(16'h0A1, 0); wr(16'h0A2, 1);
        wr_stop();
        rd(1, 0); chk("R2 first", rdata, 16'h0A0);
        rd(1, 0); chk("R2 masked keeps old", rdata, 16'h101);
        rd(1, 0); chk("R2 third", rdata, 16'h0A2);
        rd_stop();
    endtask

    task automatic t_skip();
        for (int i = 0; i < 4; i++) wr(16'h0B0 + 16'(i), 1);
        wr_stop();
        rd(1, 0); chk("R3 before skip", rdata, 16'h0B0);
        rd(0, 0); chk("R3 skip dval high", dval_n, 1);
        chk("R3 skip keeps rdata", rdata, 16'h0B0);
        rd(1, 0); chk("R3 after skip", rdata, 16'h0B2);
        rd(1, 0); chk("R3 last", rdata, 16'h0B3);
        rd_stop();
    endtask

    task automatic t_full();
        int got;
        part_reset();
        for (int i = 0; i < 16; i++) begin
            int c;
            wr(16'h200 + 16'(i), 1);
            c = (i + 1 > CAP) ? CAP : i + 1;
            chk("R6 full flag", full_n, (c >= CAP) ? 0 : 1);
            chk("R7 half flag", hfull_n, (c >= 8) ? 0 : 1);
            chk("R8 almost full", afull_n, ((CAP - c) <= 3) ? 0 : 1);
        end
        wr_stop();
        got = 0;
        for (int i = 0; i < 16; i++) begin
            rd(1, 0);
            if (dval_n == 0) begin
                chk("R6 stored word", rdata, 16'h200 + 16'(got));
                got++;
            end
        end
        rd_stop();
        chk("R6 words kept", got, CAP);
    endtask

    task automatic t_retx();
        part_reset();
        for (int i = 0; i < 8; i++) wr(16'h300 + 16'(i), 1);
        wr_stop();
        rd(1, 0); rd(1, 0);
        rd(1, 1); chk("R10 marked word", rdata, 16'h302);
        rd(1, 0); rd(1, 0);
        rd_stop();
        pulse_rt();
        chk("R10 flags follow rewind", empty_n, 1);
        for (int i = 0; i < 6; i++) begin
            rd(1, 0);
            chk("R10 replay dval", dval_n, 0);
            chk("R10 replay data", rdata, 16'h302 + 16'(i));
        end
        rd(1, 0); chk("R10 stops at write pointer", dval_n, 1);
        rd_stop();
    endtask

    task automatic t_stale();
        part_reset();
        for (int i = 0; i < 10; i++) wr(16'h400 + 16'(i), 1);
        wr_stop();
        rd(1, 1);
        for (int i = 0; i < 9; i++) rd(1, 0);
        rd_stop();
        for (int i = 0; i < 10; i++) wr(16'h410 + 16'(i), 1);
        wr_stop();
        pulse_rt();
        for (int i = 0; i < 10; i++) begin
            rd(1, 0);
            chk("R11 stale mark ignored", rdata, 16'h410 + 16'(i));
        end
        rd(1, 0); chk("R11 empty after", dval_n, 1);
        rd_stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_order();
        t_mask();
        t_skip();
        t_full();
        t_retx();
        t_stale();
        finish_run();
    end

    initial begin
        #400000;
        nchk++; nerr++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        finish_run();
    end
endmodule